// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the control unit of a processor that runs each instruction over several clock cycles. A single memory holds both instructions and data, and a single ALU is shared across all steps. The sequencer moves through one state per clock. Every instruction starts with a shared fetch step and a shared decode step. After decode it follows a path chosen by the 6-bit opcode held in the instruction register. In every state it drives every select and write strobe of the datapath.

Five instruction classes are supported: load word, store word, register-to-register arithmetic, branch-on-equal and jump. Because each class has its own path, each class takes a different number of cycles. A load takes 5, a store or arithmetic instruction takes 4, and a branch or jump takes 3. An opcode outside these classes goes straight back to fetch after decode.

All outputs depend only on the current state. The asynchronous active-low reset is released through an internal two-stage synchronizer.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: While `rst_n` is low, the outputs show the fetch pattern at once, without waiting for a clock. After `rst_n` rises, the fetch pattern holds for two more rising edges. The sequencer first leaves fetch on the third rising edge.
- R2: In fetch, `mem_rd`, `ir_wr` and `pc_wr` are 1, `alu_b_sel` = 01 (constant 4), and `addr_sel`, `alu_a_sel`, `alu_op` and `pc_src` are all 0. Fetch always moves to decode.
- R3: In decode, `alu_b_sel` = 11 (shifted immediate), `alu_a_sel` = 0 (PC) and `alu_op` = 00 (add). Every write and read strobe is 0.
- R4: Opcode 0x23 (load) runs fetch, decode, address, read and writeback, for 5 cycles. The address state has `alu_a_sel` = 1, `alu_b_sel` = 10 and `alu_op` = 00. The read state has `mem_rd` = 1 and `addr_sel` = 1. The writeback state has `reg_wr` = 1, `wb_sel` = 1 and `reg_dst` = 0.
- R5: Opcode 0x2B (store) runs fetch, decode, address and write, for 4 cycles. The write state has `mem_wr` = 1 and `addr_sel` = 1.
- R6: Opcode 0x00 (arithmetic) runs fetch, decode, execute and completion, for 4 cycles. Execute has `alu_a_sel` = 1, `alu_b_sel` = 00 and `alu_op` = 10 (function field). Completion has `reg_wr` = 1, `reg_dst` = 1 and `wb_sel` = 0.
- R7: Opcode 0x04 (branch) runs fetch, decode and branch, for 3 cycles. The branch state has `alu_a_sel` = 1, `alu_b_sel` = 00, `alu_op` = 01 (subtract), `pc_src` = 01 (held ALU result) and `pc_wr_cond` = 1, with `pc_wr` = 0.
- R8: Opcode 0x02 (jump) runs fetch, decode and jump, for 3 cycles. The jump state has `pc_wr` = 1 and `pc_src` = 10 (jump target).
- R9: Any other opcode returns to fetch straight after decode, so the instruction takes 2 cycles.
- R10: In every state, each output not named for that state is 0. `mem_rd` and `mem_wr` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 6 | Opcode field of the instruction register |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| addr_sel | output | 1 | Memory address select: 0 = PC, 1 = held ALU result |
| ir_wr | output | 1 | Instruction register load |
| alu_a_sel | output | 1 | ALU A operand: 0 = PC, 1 = register A |
| alu_b_sel | output | 2 | ALU B operand: 00 = register B, 01 = 4, 10 = immediate, 11 = immediate shifted by 2 |
| alu_op | output | 2 | ALU operation: 00 = add, 01 = subtract, 10 = function field |
| pc_src | output | 2 | PC source: 00 = ALU, 01 = held ALU result, 10 = jump target |
| pc_wr | output | 1 | Unconditional PC write |
| pc_wr_cond | output | 1 | PC write when the operands compare equal |
| reg_dst | output | 1 | Destination register select: 0 = rt field, 1 = rd field |
| wb_sel | output | 1 | Writeback source: 0 = held ALU result, 1 = memory data |
| reg_wr | output | 1 | Register file write |

## Verification
Fetch does two jobs in the same cycle. It reads the instruction from memory and it advances the PC through the shared ALU. So `mem_rd`, `ir_wr` and `pc_wr` must all be 1 in one cycle, with the address select on the PC and the ALU set to add the constant 4. The bench runs every instruction class back to back, so this shared cycle starts every test row. It compares the whole packed control word sampled in that cycle, and in every following cycle, against the pattern expected for that state. The return to that shared cycle is also checked after every class, which pins each class's cycle count.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

  typedef enum logic [3:0] {
    ST_FETCH  = 4'd0,
    ST_DECODE = 4'd1,
    ST_ADDR   = 4'd2,
    ST_RDMEM  = 4'd3,
    ST_LDWB   = 4'd4,
    ST_WRMEM  = 4'd5,
    ST_EXEC   = 4'd6,
    ST_ALUWB  = 4'd7,
    ST_BRANCH = 4'd8,
    ST_JUMP   = 4'd9
  } state_e;

  typedef enum logic [2:0] {
    CL_LOAD  = 3'd0,
    CL_STORE = 3'd1,
    CL_ARITH = 3'd2,
    CL_BEQ   = 3'd3,
    CL_JUMP  = 3'd4,
    CL_NONE  = 3'd5
  } iclass_e;

  localparam int NUM_CLASSES = 5;

  typedef struct packed {
    logic       mem_rd;
    logic       mem_wr;
    logic       addr_sel;
    logic       ir_wr;
    logic       alu_a_sel;
    logic [1:0] alu_b_sel;
    logic [1:0] alu_op;
    logic [1:0] pc_src;
    logic       pc_wr;
    logic       pc_wr_cond;
    logic       reg_dst;
    logic       wb_sel;
    logic       reg_wr;
  } ctrl_t;

  localparam logic [1:0] BSEL_REG   = 2'b00;
  localparam logic [1:0] BSEL_FOUR  = 2'b01;
  localparam logic [1:0] BSEL_IMM   = 2'b10;
  localparam logic [1:0] BSEL_IMMSH = 2'b11;

  localparam logic [1:0] AOP_ADD  = 2'b00;
  localparam logic [1:0] AOP_SUB  = 2'b01;
  localparam logic [1:0] AOP_FUNC = 2'b10;

  localparam logic [1:0] PSRC_ALU  = 2'b00;
  localparam logic [1:0] PSRC_HELD = 2'b01;
  localparam logic [1:0] PSRC_JMP  = 2'b10;

endpackage

// File: rtl/mcc_rst_sync.sv
module mcc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/mcc_opdecode.sv
module mcc_opdecode
  import mcc_pkg::*;
#(
  parameter int              OPW      = 6,
  parameter logic [OPW-1:0]  OP_LOAD  = 6'h23,
  parameter logic [OPW-1:0]  OP_STORE = 6'h2B,
  parameter logic [OPW-1:0]  OP_ARITH = 6'h00,
  parameter logic [OPW-1:0]  OP_BEQ   = 6'h04,
  parameter logic [OPW-1:0]  OP_JUMP  = 6'h02
) (
  input  logic [OPW-1:0] opcode,
  output iclass_e        iclass
);
  localparam logic [OPW-1:0] CODES [NUM_CLASSES] =
    '{OP_LOAD, OP_STORE, OP_ARITH, OP_BEQ, OP_JUMP};

  logic [NUM_CLASSES-1:0] hit;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_CLASSES; gi++) begin : g_match
      assign hit[gi] = (opcode == CODES[gi]);
    end
  endgenerate

  always_comb begin
    iclass = CL_NONE;
    for (int i = NUM_CLASSES - 1; i >= 0; i--) begin
      if (hit[i]) iclass = iclass_e'(i[2:0]);
    end
  end
endmodule

// File: rtl/mcc_next_state.sv
module mcc_next_state
  import mcc_pkg::*;
(
  input  state_e  state,
  input  iclass_e iclass,
  output state_e  state_nxt
);
  always_comb begin
    state_nxt = ST_FETCH;
    unique case (state)
      ST_FETCH:  state_nxt = ST_DECODE;
      ST_DECODE: begin
        case (iclass)
          CL_LOAD, CL_STORE: state_nxt = ST_ADDR;
          CL_ARITH:          state_nxt = ST_EXEC;
          CL_BEQ:            state_nxt = ST_BRANCH;
          CL_JUMP:           state_nxt = ST_JUMP;
          default:           state_nxt = ST_FETCH;
        endcase
      end
      ST_ADDR: begin
        case (iclass)
          CL_LOAD:  state_nxt = ST_RDMEM;
          CL_STORE: state_nxt = ST_WRMEM;
          default:  state_nxt = ST_FETCH;
        endcase
      end
      ST_RDMEM: state_nxt = ST_LDWB;
      ST_EXEC:  state_nxt = ST_ALUWB;
      default:  state_nxt = ST_FETCH;
    endcase
  end
endmodule

// File: rtl/mcc_ctrl_decode.sv
module mcc_ctrl_decode
  import mcc_pkg::*;
(
  input  state_e state,
  output ctrl_t  ctrl
);
  always_comb begin
    ctrl = '0;
    unique case (state)
      ST_FETCH: begin
        ctrl.mem_rd    = 1'b1;
        ctrl.ir_wr     = 1'b1;
        ctrl.pc_wr     = 1'b1;
        ctrl.alu_b_sel = BSEL_FOUR;
        ctrl.alu_op    = AOP_ADD;
        ctrl.pc_src    = PSRC_ALU;
      end
      ST_DECODE: begin
        ctrl.alu_b_sel = BSEL_IMMSH;
        ctrl.alu_op    = AOP_ADD;
      end
      ST_ADDR: begin
        ctrl.alu_a_sel = 1'b1;
        ctrl.alu_b_sel = BSEL_IMM;
        ctrl.alu_op    = AOP_ADD;
      end
      ST_RDMEM: begin
        ctrl.mem_rd   = 1'b1;
        ctrl.addr_sel = 1'b1;
      end
      ST_LDWB: begin
        ctrl.reg_wr  = 1'b1;
        ctrl.wb_sel  = 1'b1;
        ctrl.reg_dst = 1'b0;
      end
      ST_WRMEM: begin
        ctrl.mem_wr   = 1'b1;
        ctrl.addr_sel = 1'b1;
      end
      ST_EXEC: begin
        ctrl.alu_a_sel = 1'b1;
        ctrl.alu_b_sel = BSEL_REG;
        ctrl.alu_op    = AOP_FUNC;
      end
      ST_ALUWB: begin
        ctrl.reg_wr  = 1'b1;
        ctrl.reg_dst = 1'b1;
        ctrl.wb_sel  = 1'b0;
      end
      ST_BRANCH: begin
        ctrl.alu_a_sel  = 1'b1;
        ctrl.alu_b_sel  = BSEL_REG;
        ctrl.alu_op     = AOP_SUB;
        ctrl.pc_src     = PSRC_HELD;
        ctrl.pc_wr_cond = 1'b1;
      end
      ST_JUMP: begin
        ctrl.pc_wr  = 1'b1;
        ctrl.pc_src = PSRC_JMP;
      end
      default: ctrl = '0;
    endcase
  end
endmodule

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm
  import mcc_pkg::*;
#(
  parameter int             OPW        = 6,
  parameter int             RST_STAGES = 2,
  parameter logic [OPW-1:0] OP_LOAD    = 6'h23,
  parameter logic [OPW-1:0] OP_STORE   = 6'h2B,
  parameter logic [OPW-1:0] OP_ARITH   = 6'h00,
  parameter logic [OPW-1:0] OP_BEQ     = 6'h04,
  parameter logic [OPW-1:0] OP_JUMP    = 6'h02
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [OPW-1:0] opcode,
  output logic           mem_rd,
  output logic           mem_wr,
  output logic           addr_sel,
  output logic           ir_wr,
  output logic           alu_a_sel,
  output logic [1:0]     alu_b_sel,
  output logic [1:0]     alu_op,
  output logic [1:0]     pc_src,
  output logic           pc_wr,
  output logic           pc_wr_cond,
  output logic           reg_dst,
  output logic           wb_sel,
  output logic           reg_wr
);
  logic    rst_q_n;
  state_e  state_q;
  state_e  state_d;
  iclass_e iclass;
  ctrl_t   ctrl;

  mcc_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  mcc_opdecode #(
    .OPW      (OPW),
    .OP_LOAD  (OP_LOAD),
    .OP_STORE (OP_STORE),
    .OP_ARITH (OP_ARITH),
    .OP_BEQ   (OP_BEQ),
    .OP_JUMP  (OP_JUMP)
  ) u_opdecode (
    .opcode (opcode),
    .iclass (iclass)
  );

  mcc_next_state u_next (
    .state     (state_q),
    .iclass    (iclass),
    .state_nxt (state_d)
  );

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) state_q <= ST_FETCH;
    else          state_q <= state_d;
  end

  mcc_ctrl_decode u_ctrl (
    .state (state_q),
    .ctrl  (ctrl)
  );

  assign mem_rd     = ctrl.mem_rd;
  assign mem_wr     = ctrl.mem_wr;
  assign addr_sel   = ctrl.addr_sel;
  assign ir_wr      = ctrl.ir_wr;
  assign alu_a_sel  = ctrl.alu_a_sel;
  assign alu_b_sel  = ctrl.alu_b_sel;
  assign alu_op     = ctrl.alu_op;
  assign pc_src     = ctrl.pc_src;
  assign pc_wr      = ctrl.pc_wr;
  assign pc_wr_cond = ctrl.pc_wr_cond;
  assign reg_dst    = ctrl.reg_dst;
  assign wb_sel     = ctrl.wb_sel;
  assign reg_wr     = ctrl.reg_wr;
endmodule

// File: rtl/mcc_checker.sv
module mcc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       mem_rd,
  input logic       mem_wr,
  input logic       addr_sel,
  input logic       ir_wr,
  input logic [1:0] alu_b_sel,
  input logic [1:0] pc_src,
  input logic       pc_wr,
  input logic       pc_wr_cond,
  input logic       reg_dst,
  input logic       wb_sel,
  input logic       reg_wr
);
  a_r10_mem_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  a_r2_fetch_shared: assert property (@(posedge clk) disable iff (!rst_n)
    ir_wr |-> (mem_rd && pc_wr && !addr_sel && alu_b_sel == 2'b01));

  a_r3_decode_follows: assert property (@(posedge clk) disable iff (!rst_n)
    ir_wr |=> (alu_b_sel == 2'b11 && !ir_wr && !pc_wr && !mem_rd &&
               !mem_wr && !reg_wr && !pc_wr_cond));

  a_r4_load_wb_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && wb_sel) |-> ($past(mem_rd) && $past(addr_sel) && !reg_dst));

  a_r6_arith_done_to_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_dst) |=> ir_wr);

  a_r7_branch_to_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    pc_wr_cond |=> ir_wr);

  a_r8_jump_to_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_wr && pc_src == 2'b10) |=> ir_wr);
endmodule

bind mc_ctrl_fsm mcc_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_q_n),
  .mem_rd     (mem_rd),
  .mem_wr     (mem_wr),
  .addr_sel   (addr_sel),
  .ir_wr      (ir_wr),
  .alu_b_sel  (alu_b_sel),
  .pc_src     (pc_src),
  .pc_wr      (pc_wr),
  .pc_wr_cond (pc_wr_cond),
  .reg_dst    (reg_dst),
  .wb_sel     (wb_sel),
  .reg_wr     (reg_wr)
);

// File: tb/mc_ctrl_fsm_bench.sv
module mc_ctrl_fsm_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] opcode = 6'h3F;
  logic mem_rd, mem_wr, addr_sel, ir_wr, alu_a_sel, pc_wr, pc_wr_cond;
  logic reg_dst, wb_sel, reg_wr;
  logic [1:0] alu_b_sel, alu_op, pc_src;
  logic [15:0] obs;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  mc_ctrl_fsm u_mc_ctrl_fsm (
    .clk(clk), .rst_n(rst_n), .opcode(opcode),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .addr_sel(addr_sel), .ir_wr(ir_wr),
    .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel), .alu_op(alu_op),
    .pc_src(pc_src), .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond),
    .reg_dst(reg_dst), .wb_sel(wb_sel), .reg_wr(reg_wr)
  );

  assign obs = {mem_rd, mem_wr, addr_sel, ir_wr, alu_a_sel, alu_b_sel,
                alu_op, pc_src, pc_wr, pc_wr_cond, reg_dst, wb_sel, reg_wr};

  // Expected control words, bit order as packed into obs
  localparam logic [15:0] W_FETCH  = 16'h9210;
  localparam logic [15:0] W_DECODE = 16'h0600;
  localparam logic [15:0] W_ADDR   = 16'h0C00;
  localparam logic [15:0] W_RDMEM  = 16'hA000;
  localparam logic [15:0] W_LDWB   = 16'h0003;
  localparam logic [15:0] W_WRMEM  = 16'h6000;
  localparam logic [15:0] W_EXEC   = 16'h0900;
  localparam logic [15:0] W_ALUWB  = 16'h0005;
  localparam logic [15:0] W_BRANCH = 16'h08A8;
  localparam logic [15:0] W_JUMP   = 16'h0050;

  typedef struct packed {
    logic [5:0]  op;
    logic [2:0]  len;
    logic [15:0] w1;
    logic [15:0] w2;
    logic [15:0] w3;
    logic [15:0] w4;
    logic [23:0] tag;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{6'h23, 3'd5, W_DECODE, W_ADDR,   W_RDMEM, W_LDWB, "R4 "},
    '{6'h2B, 3'd4, W_DECODE, W_ADDR,   W_WRMEM, 16'h0,  "R5 "},
    '{6'h00, 3'd4, W_DECODE, W_EXEC,   W_ALUWB, 16'h0,  "R6 "},
    '{6'h04, 3'd3, W_DECODE, W_BRANCH, 16'h0,   16'h0,  "R7 "},
    '{6'h02, 3'd3, W_DECODE, W_JUMP,   16'h0,   16'h0,  "R8 "},
    '{6'h3F, 3'd2, W_DECODE, 16'h0,    16'h0,   16'h0,  "R9 "},
    '{6'h22, 3'd2, W_DECODE, 16'h0,    16'h0,   16'h0,  "R9 "},
    '{6'h23, 3'd5, W_DECODE, W_ADDR,   W_RDMEM, W_LDWB, "R4 "}
  };

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s control word got %h expected %h at %0t", req, got, exp, $time);
    end
    if (mem_rd && mem_wr) begin
      errors++;
      $display("FAIL R10 read and write strobes together got %b%b expected not 11", mem_rd, mem_wr);
    end
  endtask

  // Entered at a negedge while in fetch; leaves at the negedge of the next fetch
  task automatic run_vec(input vec_t v);
    logic [15:0] ws [4];
    ws[0] = v.w1; ws[1] = v.w2; ws[2] = v.w3; ws[3] = v.w4;
    chk("R2 fetch", obs, W_FETCH);
    opcode = v.op;
    for (int k = 1; k < int'(v.len); k++) begin
      @(negedge clk);
      if (k == 1) chk("R3 decode", obs, ws[0]);
      else        chk(string'(v.tag), obs, ws[k-1]);
    end
    @(negedge clk);
    chk({string'(v.tag), " length / R2 return"}, obs, W_FETCH);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired got timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset holds fetch, then two more edges after release
    #1;
    chk("R1 in reset", obs, W_FETCH);
    repeat (3) @(negedge clk);
    opcode = 6'h00;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 hold edge 1", obs, W_FETCH);
    @(negedge clk);
    chk("R1 hold edge 2", obs, W_FETCH);

    // Table walk of every class, back to back
    for (int i = 0; i < NVEC; i++) run_vec(VECS[i]);

    // R1: asynchronous reset in the middle of an arithmetic instruction
    opcode = 6'h00;
    @(negedge clk);
    chk("R3 decode", obs, W_DECODE);
    @(negedge clk);
    chk("R6 exec", obs, W_EXEC);
    #1 rst_n = 1'b0;
    #0.5;
    chk("R1 async entry", obs, W_FETCH);
    @(negedge clk);
    rst_n = 1'b1;
    opcode = 6'h04;
    @(negedge clk);
    chk("R1 after release 1", obs, W_FETCH);
    @(negedge clk);
    run_vec(VECS[3]);

    // R9 then R8: unknown opcodes back to back, then a jump
    run_vec(VECS[5]);
    run_vec(VECS[6]);
    run_vec(VECS[4]);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule